// File: doc/BRIEF.md
# Branch Condition Flag Evaluator

This block decides whether a conditional branch is taken. It keeps a four-bit status flag register holding zero, negative, overflow and carry. An arithmetic or logic operation loads this register when it asserts a write enable. The register then holds its value across any number of later instructions until the next flag-setting operation arrives. Because of this, a branch can test flags produced well before it.

A four-bit condition selector picks one of sixteen tests, which are applied to the stored flags. The result appears combinationally on a single `taken` output. Each even selector code has an odd partner that yields the complementary result. The tests cover the raw flags, the unsigned orderings and the signed orderings.

A parameter sets how carry encodes borrow after a subtraction. One setting treats carry set as borrow; the other treats carry clear as borrow. The unsigned orderings read this derived borrow. The raw carry tests are unaffected by the parameter.

Top module: `bce_branch_unit`

## Requirements
- R1: While `rst_n` is low the flag register is cleared, so `flags_out` reads 0 after reset.
- R2: At a rising clock edge with `flag_we` high, `flags_out` takes the value of `flag_in`, and `taken` then evaluates against the new flags. Bit order in both vectors is [3]=zero, [2]=negative, [1]=overflow, [0]=carry.
- R3: At a rising edge with `flag_we` low, `flag_in` is ignored, and `flags_out` and `taken` keep their values.
- R4: Selector codes 0 to 7 test the raw flags, in this order: 0 zero set, 1 zero clear, 2 negative set, 3 negative clear, 4 overflow set, 5 overflow clear, 6 carry set, 7 carry clear. The carry codes do not depend on the borrow parameter.
- R5: Code 8 (unsigned below) is taken on borrow. Code 9 (unsigned above-or-equal) is taken on no borrow.
- R6: Code 10 (unsigned below-or-equal) is taken on borrow or zero. Code 11 (unsigned above) is taken when there is no borrow and zero is clear.
- R7: Code 12 (signed less) is taken when negative differs from overflow. Code 13 (signed greater-or-equal) is taken when negative equals overflow.
- R8: Code 14 (signed less-or-equal) is taken when negative differs from overflow or zero is set. Code 15 (signed greater) is taken when negative equals overflow and zero is clear.
- R9: Borrow equals carry when `BORROW_ON_CLEAR` is 0, and equals the inverse of carry when it is 1.
- R10: For any flags, each odd selector code gives the complement of the result of the even code below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_we | input | 1 | Load `flag_in` into the flag register at the next rising edge |
| flag_in | input | 4 | New flags {zero, negative, overflow, carry} |
| cond_sel | input | 4 | Branch condition code |
| taken | output | 1 | Branch decision for the stored flags |
| flags_out | output | 4 | Stored flags {zero, negative, overflow, carry} |

## Verification
The hard case is a branch that reads flags produced several operations earlier. To create it, the flags must be loaded and then held through cycles in which `flag_in` changes while the write enable stays low. The bench builds such gaps between random loads. At each held state it sweeps all sixteen codes. Two instances with opposite borrow settings receive identical stimulus, so every unsigned ordering is compared under both polarities for the same stored carry.

// File: rtl/bce_pkg.sv
package bce_pkg;

    localparam int FLAG_W = 4;
    localparam int SEL_W  = 4;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } bce_flags_t;

    // Upper three selector bits pick a test; bit 0 inverts it.
    typedef enum logic [SEL_W-2:0] {
        PR_ZERO  = 3'd0,
        PR_NEG   = 3'd1,
        PR_OVF   = 3'd2,
        PR_CARRY = 3'd3,
        PR_ULT   = 3'd4,
        PR_ULE   = 3'd5,
        PR_SLT   = 3'd6,
        PR_SLE   = 3'd7
    } bce_pair_e;

    typedef struct packed {
        bce_flags_t flags;
    } bce_state_t;

endpackage

// File: rtl/bce_flag_reg.sv
module bce_flag_reg
    import bce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  bce_flags_t flags_in,
    output bce_flags_t flags_q
);

    bce_state_t st_d;
    bce_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.flags = flags_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flags;

endmodule

// File: rtl/bce_cond_eval.sv
module bce_cond_eval
    import bce_pkg::*;
#(
    parameter bit BORROW_ON_CLEAR = 1'b0
) (
    input  bce_flags_t       flags,
    input  logic [SEL_W-1:0] sel,
    output logic             taken
);

    logic      borrow;
    logic      sgn_lt;
    logic      base;
    bce_pair_e pair;

    assign borrow = flags.c ^ BORROW_ON_CLEAR;
    assign sgn_lt = flags.n ^ flags.v;
    assign pair   = bce_pair_e'(sel[SEL_W-1:1]);

    always_comb begin
        base = 1'b0;
        unique case (pair)
            PR_ZERO:  base = flags.z;
            PR_NEG:   base = flags.n;
            PR_OVF:   base = flags.v;
            PR_CARRY: base = flags.c;
            PR_ULT:   base = borrow;
            PR_ULE:   base = borrow | flags.z;
            PR_SLT:   base = sgn_lt;
            PR_SLE:   base = sgn_lt | flags.z;
            default:  base = 1'b0;
        endcase
    end

    assign taken = base ^ sel[0];

endmodule

// File: rtl/bce_branch_unit.sv
module bce_branch_unit
    import bce_pkg::*;
#(
    parameter bit BORROW_ON_CLEAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_in,
    input  logic [SEL_W-1:0]  cond_sel,
    output logic              taken,
    output logic [FLAG_W-1:0] flags_out
);

    bce_flags_t flags_q;

    bce_flag_reg u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (flag_we),
        .flags_in (bce_flags_t'(flag_in)),
        .flags_q  (flags_q)
    );

    bce_cond_eval #(
        .BORROW_ON_CLEAR (BORROW_ON_CLEAR)
    ) u_eval (
        .flags (flags_q),
        .sel   (cond_sel),
        .taken (taken)
    );

    assign flags_out = flags_q;

endmodule

// File: rtl/bce_branch_unit_chk.sv
module bce_branch_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flag_we,
    input logic [3:0] flag_in,
    input logic [3:0] cond_sel,
    input logic       taken,
    input logic [3:0] flags_out
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> flags_out == 4'b0000);  // R1

    AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flags_out == $past(flag_in));  // R2

    AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags_out));  // R3

    AST_ZERO_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 4'd0 |-> taken == flags_out[3]);  // R4

    AST_SIGNED_GE: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 4'd13 |-> taken == (flags_out[2] == flags_out[1]));  // R7

    AST_SIGNED_GT: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == 4'd15 |-> taken == ((flags_out[2] == flags_out[1]) && !flags_out[3]));  // R8

endmodule

bind bce_branch_unit bce_branch_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_we   (flag_we),
    .flag_in   (flag_in),
    .cond_sel  (cond_sel),
    .taken     (taken),
    .flags_out (flags_out)
);

// File: tb/bce_branch_unit_tb.sv
`timescale 1ns/1ps
module bce_branch_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flag_we = 1'b0;
    logic [3:0] flag_in = 4'h0;
    logic [3:0] cond_sel = 4'h0;
    logic       taken_a;
    logic       taken_b;
    logic [3:0] flags_a;
    logic [3:0] flags_b;

    int checks = 0;
    int errors = 0;
    logic [3:0] model_flags = 4'h0;

    always #2.5 clk = ~clk;

    bce_branch_unit #(.BORROW_ON_CLEAR(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_in(flag_in),
        .cond_sel(cond_sel), .taken(taken_a), .flags_out(flags_a));

    bce_branch_unit #(.BORROW_ON_CLEAR(1'b1)) u_dut_inv (
        .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_in(flag_in),
        .cond_sel(cond_sel), .taken(taken_b), .flags_out(flags_b));

    function automatic logic exp_taken(input logic [3:0] f, input logic [3:0] s, input logic pol);
        logic z, n, v, c, brw, r;
        z = f[3]; n = f[2]; v = f[1]; c = f[0];
        brw = pol ? !c : c;
        case (s)
            4'd0:  r = z;
            4'd1:  r = !z;
            4'd2:  r = n;
            4'd3:  r = !n;
            4'd4:  r = v;
            4'd5:  r = !v;
            4'd6:  r = c;
            4'd7:  r = !c;
            4'd8:  r = brw;
            4'd9:  r = !brw;
            4'd10: r = brw || z;
            4'd11: r = !brw && !z;
            4'd12: r = n != v;
            4'd13: r = n == v;
            4'd14: r = (n != v) || z;
            default: r = (n == v) && !z;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [3:0] s);
        if (s < 4'd8)       return "R4";
        else if (s < 4'd10) return "R5/R9";
        else if (s < 4'd12) return "R6/R9";
        else if (s < 4'd14) return "R7";
        else                return "R8";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Sweep all codes on both polarities against the model flags.
    task automatic sweep(input string tag);
        for (int s = 0; s < 16; s++) begin
            cond_sel = s[3:0];
            #0.2;
            check({req_of(s[3:0]), " pol0 ", tag}, taken_a, exp_taken(model_flags, s[3:0], 1'b0));
            check({req_of(s[3:0]), " pol1 ", tag}, taken_b, exp_taken(model_flags, s[3:0], 1'b1));
            if (s[0]) begin
                // R10: odd code complements even partner
                check("R10 pair complement", taken_a, !exp_taken(model_flags, s[3:0] - 4'd1, 1'b0));
            end
        end
    endtask

    task automatic step(input logic we, input logic [3:0] f);
        @(negedge clk);
        flag_we = we;
        flag_in = f;
        @(posedge clk);
        #1;
        if (we) model_flags = f;
        check(we ? "R2 load a" : "R3 hold a", flags_a, model_flags);
        check(we ? "R2 load b" : "R3 hold b", flags_b, model_flags);
    endtask

    initial begin
        #50000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        #1;
        check("R1 reset flags a", flags_a, 4'h0);
        check("R1 reset flags b", flags_b, 4'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release", flags_a, 4'h0);
        sweep("reset");

        // Directed corners: each carry value with zero, signed mismatch cases
        step(1'b1, 4'b0001); sweep("c only");
        step(1'b1, 4'b0000); sweep("all clear");
        step(1'b1, 4'b1001); sweep("z c");
        step(1'b1, 4'b1000); sweep("z only");
        step(1'b1, 4'b0100); sweep("n only");
        step(1'b1, 4'b0010); sweep("v only");
        step(1'b1, 4'b0110); sweep("n v");
        step(1'b1, 4'b1111); sweep("all set");

        // R3: flags ignored while write enable low, state survives several ops
        step(1'b1, 4'b0101);
        for (int k = 0; k < 4; k++) begin
            step(1'b0, ~4'b0101 ^ k[3:0]);
            sweep("R3 held");
        end

        // Random mix of loads and holds
        for (int i = 0; i < 300; i++) begin
            step(($urandom % 3) == 0, 4'($urandom));
            sweep("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule